// File: doc/BRIEF.md
# Cache Maintenance Register Port with Associative Purge

This block gives software direct access to a cache's tag store and line storage through two address windows on a simple request/response register bus. The tag window lets software write an entry's tag, dirty and valid bits outright, or perform an associative purge. In an associative purge, the tag carried in the write data is compared with the tag held by the indexed entry. On a match the entry's valid and dirty bits are replaced, and a dirty line is first written back through a separate line write-back port. On a mismatch nothing happens. The data window reads or writes one longword of a line.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls while a write-back is outstanding. During that stall the requester must hold its request steady, and the request is taken once the stall ends. A read returns its word with `rsp_valid` for one cycle, on the cycle after it is accepted. This response has no back-pressure. The write-back side is also valid/ready. `wb_valid` stays high with stable address and data until the cycle in which `wb_ready` is high.

A mode input selects how many address bits form the entry index, which allows the larger or the half-size cache organisation.

Top module: `cmp_purge_port`

## Requirements
- R1: An address whose bits [31:24] equal 0xF0 selects the tag window, and 0xF1 selects the data window. A write to any other address changes no state. A read of any other address returns zero.
- R2: A tag-window write with address bit 3 clear stores write-data bits [28:10] as the tag, bit 1 as dirty and bit 0 as valid. A tag-window read returns the tag in bits [28:10], dirty in bit 1 and valid in bit 0, with all other bits zero.
- R3: The entry index is address bits [12:4] when `mode_32k` is 1. When `mode_32k` is 0 it is bits [11:4], and bit 12 is ignored.
- R4: A tag-window write with address bit 3 set, whose tag matches a clean entry, replaces that entry's valid and dirty bits from write-data bits 0 and 1. It keeps the stored tag and issues no write-back.
- R5: An associative write whose tag does not match leaves the entry unchanged and issues no write-back.
- R6: An associative write whose tag matches a dirty entry raises `wb_valid`. `wb_addr` is {3'b0, tag, index[5:0], 4'b0}, and `wb_data` holds longword k in bits [32k+31:32k]. The status update becomes visible from the cycle after the `wb_valid`/`wb_ready` handshake.
- R7: A data-window read returns the longword selected by address bits [3:2] of the indexed line, with `rsp_valid` on the cycle after acceptance.
- R8: A data-window write stores the addressed longword and leaves the entry's tag, dirty and valid bits unchanged.
- R9: Reset clears the tag, dirty and valid bits of every entry.
- R10: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_addr` and `wb_data` hold their values.
- R11: `req_ready` is low while a write-back is outstanding, and `rsp_valid` follows only accepted reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_32k | input | 1 | 1: 9-bit entry index; 0: 8-bit entry index |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Read data |
| wb_valid | output | 1 | Line write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | 32 | Line address of the write-back |
| wb_data | output | 128 | Four longwords of the line |

## Verification
The write-back acknowledge and a new register request can arrive in the same cycle. In that cycle the purge's status update and the held request compete for the same entry. The bench holds a read of the purged entry on the bus while `wb_ready` rises. It then checks two things: that the read waited exactly one cycle, and that the read returned the already-updated status, never the stale one.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int TAG_LO     = 10;
  localparam int TAG_HI     = 28;
  localparam int TAG_W      = TAG_HI - TAG_LO + 1;
  localparam int LINE_WORDS = 4;
  localparam int WORD_SEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W      = WORD_SEL_W + 2;
  localparam int LOW_IDX_W  = TAG_LO - OFF_W;
  localparam int LINE_BITS  = LINE_WORDS * 32;

  typedef enum logic [1:0] {WIN_NONE, WIN_TAG, WIN_DATA} win_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             dirty;
    logic             valid;
  } tag_ent_t;
endpackage

// File: rtl/cmp_decode.sv
module cmp_decode
  import cmp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic [31:0]           addr,
  input  logic                  mode_32k,
  output win_e                  win,
  output logic [IDX_W-1:0]      idx,
  output logic                  assoc,
  output logic [WORD_SEL_W-1:0] word
);
  logic unused_bits;
  assign unused_bits = ^{addr[23:OFF_W+IDX_W], addr[1:0]};

  always_comb begin
    case (addr[31:24])
      8'hF0:   win = WIN_TAG;
      8'hF1:   win = WIN_DATA;
      default: win = WIN_NONE;
    endcase
    idx = addr[OFF_W +: IDX_W];
    if (!mode_32k) idx[IDX_W-1] = 1'b0;
  end

  assign assoc = addr[3];
  assign word  = addr[2 +: WORD_SEL_W];
endmodule

// File: rtl/cmp_tag_store.sv
module cmp_tag_store
  import cmp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output tag_ent_t         rd_ent,
  input  logic             we,
  input  logic             we_tag,
  input  logic [IDX_W-1:0] wr_idx,
  input  tag_ent_t         wr_ent
);
  localparam int N = 1 << IDX_W;
  tag_ent_t ents [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ents[i] <= '0;
    end else if (we) begin
      if (we_tag) ents[wr_idx].tag <= wr_ent.tag;
      ents[wr_idx].dirty <= wr_ent.dirty;
      ents[wr_idx].valid <= wr_ent.valid;
    end
  end

  assign rd_ent = ents[rd_idx];
endmodule

// File: rtl/cmp_data_store.sv
module cmp_data_store
  import cmp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [WORD_SEL_W-1:0] wr_word,
  input  logic [31:0]           wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [LINE_BITS-1:0]  rd_line
);
  localparam int N = (1 << IDX_W) * LINE_WORDS;
  logic [31:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[{wr_idx, wr_word}] <= wr_data;
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign rd_line[w*32 +: 32] = mem[{rd_idx, WORD_SEL_W'(w)}];
  end
endmodule

// File: rtl/cmp_purge_port.sv
module cmp_purge_port
  import cmp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_32k,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [31:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 wb_valid,
  input  logic                 wb_ready,
  output logic [31:0]          wb_addr,
  output logic [LINE_BITS-1:0] wb_data
);
  typedef enum logic {ST_IDLE, ST_WB} st_e;
  st_e state;

  win_e                  dec_win;
  logic [IDX_W-1:0]      dec_idx;
  logic                  dec_assoc;
  logic [WORD_SEL_W-1:0] dec_word;

  logic [IDX_W-1:0]     pend_idx;
  logic                 pend_u, pend_v;
  logic [IDX_W-1:0]     rd_idx;
  tag_ent_t             cur;
  logic [LINE_BITS-1:0] line;

  logic                 ts_we, ts_we_tag, ds_we, go_wb;
  logic [IDX_W-1:0]     ts_idx;
  tag_ent_t             ts_ent;
  logic                 accept, tag_hit;
  logic [31:0]          rd_word;

  cmp_decode #(.IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .mode_32k(mode_32k), .win(dec_win),
    .idx(dec_idx), .assoc(dec_assoc), .word(dec_word)
  );

  assign rd_idx = (state == ST_WB) ? pend_idx : dec_idx;

  cmp_tag_store #(.IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_ent(cur),
    .we(ts_we), .we_tag(ts_we_tag), .wr_idx(ts_idx), .wr_ent(ts_ent)
  );

  cmp_data_store #(.IDX_W(IDX_W)) u_data (
    .clk(clk), .we(ds_we), .wr_idx(dec_idx), .wr_word(dec_word),
    .wr_data(req_wdata), .rd_idx(rd_idx), .rd_line(line)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign tag_hit   = (cur.tag == req_wdata[TAG_HI:TAG_LO]);

  always_comb begin
    ts_we     = 1'b0;
    ts_we_tag = 1'b0;
    ds_we     = 1'b0;
    go_wb     = 1'b0;
    ts_idx    = dec_idx;
    ts_ent    = '{tag: req_wdata[TAG_HI:TAG_LO], dirty: req_wdata[1], valid: req_wdata[0]};
    if (state == ST_WB) begin
      if (wb_ready) begin
        ts_we        = 1'b1;
        ts_idx       = pend_idx;
        ts_ent.dirty = pend_u;
        ts_ent.valid = pend_v;
      end
    end else if (accept && req_write) begin
      if (dec_win == WIN_TAG) begin
        if (!dec_assoc) begin
          ts_we     = 1'b1;
          ts_we_tag = 1'b1;
        end else if (tag_hit) begin
          if (cur.dirty) go_wb = 1'b1;
          else           ts_we = 1'b1;
        end
      end else if (dec_win == WIN_DATA) begin
        ds_we = 1'b1;
      end
    end
  end

  always_comb begin
    case (dec_win)
      WIN_TAG:  rd_word = {3'b0, cur.tag, {(TAG_LO-2){1'b0}}, cur.dirty, cur.valid};
      WIN_DATA: rd_word = line[dec_word*32 +: 32];
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_idx  <= '0;
      pend_u    <= 1'b0;
      pend_v    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) rsp_rdata <= rd_word;
      if (go_wb) begin
        state    <= ST_WB;
        pend_idx <= dec_idx;
        pend_u   <= req_wdata[1];
        pend_v   <= req_wdata[0];
      end else if (state == ST_WB && wb_ready) begin
        state <= ST_IDLE;
      end
    end
  end

  assign wb_valid = (state == ST_WB);
  assign wb_addr  = {3'b0, cur.tag, pend_idx[LOW_IDX_W-1:0], {OFF_W{1'b0}}};
  assign wb_data  = line;
endmodule

// File: rtl/cmp_purge_port_chk.sv
module cmp_purge_port_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic [31:0]  req_addr,
  input logic         rsp_valid,
  input logic [31:0]  rsp_rdata,
  input logic         wb_valid,
  input logic         wb_ready,
  input logic [31:0]  wb_addr,
  input logic [127:0] wb_data
);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !req_ready);

  assert_rsp_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  assert_outside_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_addr[31:25] != 7'h78) |-> rsp_rdata == 32'h0);

  assert_wb_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(req_valid && req_ready && req_write &&
                              req_addr[31:24] == 8'hF0 && req_addr[3]));

  assert_wb_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> !wb_valid && req_ready);
endmodule

bind cmp_purge_port cmp_purge_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/cmp_purge_port_tb.sv
module cmp_purge_port_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_32k = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         wb_valid;
  logic         wb_ready = 1'b0;
  logic [31:0]  wb_addr;
  logic [127:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [18:0] TG_A = 19'h12345;
  localparam logic [18:0] TG_B = 19'h0ABCD;
  localparam logic [18:0] TG_C = 19'h7F001;
  logic [31:0] lw [4];

  always #10 clk = ~clk;

  cmp_purge_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_32k(mode_32k), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [31:0] tword(logic [18:0] t, logic u, logic v);
    return {3'b0, t, 8'b0, u, v};
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [31:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [31:0] a, output logic [31:0] d, output int waits);
    waits = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) begin @(negedge clk); waits++; end
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    check(rsp_valid === 1'b1, "R7 rsp_valid", rsp_valid, 1);
  endtask

  task automatic t_reset();
    logic [31:0] d; int w;
    check(req_ready === 1'b1 && wb_valid === 1'b0 && rsp_valid === 1'b0,
          "R9 idle outputs", {req_ready, wb_valid, rsp_valid}, 3'b100);
    bus_read(32'hF000_0050, d, w);
    check(d === 32'h0, "R9 entry cleared", d, 0);
    bus_read(32'hF000_1FF0, d, w);
    check(d === 32'h0, "R9 last entry cleared", d, 0);
  endtask

  task automatic t_direct();
    logic [31:0] d; int w;
    bus_write(32'hF000_0050, tword(TG_A, 1'b1, 1'b1) | 32'hE000_03FC);
    bus_read(32'hF000_0050, d, w);
    check(d === tword(TG_A, 1'b1, 1'b1), "R2 direct tag write", d, tword(TG_A, 1'b1, 1'b1));
  endtask

  task automatic t_data();
    logic [31:0] d; int w;
    for (int k = 0; k < 4; k++) begin
      lw[k] = 32'hA5A5_0000 + 32'(k * 32'h1111);
      bus_write(32'hF100_0050 + 32'(k * 4), lw[k]);
    end
    for (int k = 3; k >= 0; k--) begin
      bus_read(32'hF100_0050 + 32'(k * 4), d, w);
      check(d === lw[k], "R7 longword select", d, lw[k]);
    end
    bus_read(32'hF000_0050, d, w);
    check(d === tword(TG_A, 1'b1, 1'b1), "R8 status kept", d, tword(TG_A, 1'b1, 1'b1));
  endtask

  task automatic t_outside();
    logic [31:0] d; int w;
    bus_write(32'hF200_0050, 32'hDEAD_BEEF);
    bus_write(32'hF200_0058, tword(TG_A, 1'b0, 1'b0));
    bus_read(32'hF200_0050, d, w);
    check(d === 32'h0, "R1 outside read zero", d, 0);
    bus_read(32'hF100_0050, d, w);
    check(d === lw[0], "R1 data untouched", d, lw[0]);
    bus_read(32'hF000_0050, d, w);
    check(d === tword(TG_A, 1'b1, 1'b1), "R1 tag untouched", d, tword(TG_A, 1'b1, 1'b1));
  endtask

  task automatic t_mismatch();
    logic [31:0] d; int w;
    bus_write(32'hF000_0058, tword(TG_A ^ 19'h1, 1'b0, 1'b0));
    check(wb_valid === 1'b0 && req_ready === 1'b1, "R5 no write-back",
          {wb_valid, req_ready}, 2'b01);
    bus_read(32'hF000_0050, d, w);
    check(d === tword(TG_A, 1'b1, 1'b1), "R5 entry unchanged", d, tword(TG_A, 1'b1, 1'b1));
  endtask

  task automatic t_clean();
    logic [31:0] d; int w;
    bus_write(32'hF000_0060, tword(TG_B, 1'b0, 1'b1));
    bus_write(32'hF000_0068, tword(TG_B, 1'b1, 1'b0));
    check(wb_valid === 1'b0, "R4 clean hit no write-back", wb_valid, 0);
    bus_read(32'hF000_0060, d, w);
    check(d === tword(TG_B, 1'b1, 1'b0), "R4 status replaced", d, tword(TG_B, 1'b1, 1'b0));
  endtask

  task automatic t_dirty();
    logic [31:0] d; int w; logic [31:0] ea; logic [127:0] ed;
    ea = {3'b0, TG_A, 6'd5, 4'b0};
    ed = {lw[3], lw[2], lw[1], lw[0]};
    wb_ready = 1'b0;
    bus_write(32'hF000_0058, tword(TG_A, 1'b0, 1'b0));
    check(wb_valid === 1'b1 && req_ready === 1'b0, "R6 write-back raised, R11 stall",
          {wb_valid, req_ready}, 2'b10);
    check(wb_addr === ea, "R6 write-back address", wb_addr, ea);
    check(wb_data === ed, "R6 write-back data", wb_data, ed);
    repeat (2) @(negedge clk);
    check(wb_valid === 1'b1 && wb_addr === ea && wb_data === ed, "R10 hold under stall",
          {wb_valid, wb_addr}, {1'b1, ea});
    wb_ready = 1'b1;
    bus_read(32'hF000_0050, d, w);
    wb_ready = 1'b0;
    check(w == 1, "R11 request waits for acknowledge", w, 1);
    check(d === tword(TG_A, 1'b0, 1'b0), "R6 status after acknowledge", d, tword(TG_A, 1'b0, 1'b0));
    check(wb_valid === 1'b0, "R6 write-back released", wb_valid, 0);
  endtask

  task automatic t_mode();
    logic [31:0] d; int w;
    mode_32k = 1'b0;
    bus_write(32'hF000_1070, tword(TG_C, 1'b0, 1'b1));
    bus_read(32'hF000_0070, d, w);
    check(d === tword(TG_C, 1'b0, 1'b1), "R3 bit 12 ignored in small mode", d, tword(TG_C, 1'b0, 1'b1));
    mode_32k = 1'b1;
    bus_read(32'hF000_1070, d, w);
    check(d === 32'h0, "R3 bit 12 indexes in large mode", d, 0);
    bus_read(32'hF000_0070, d, w);
    check(d === tword(TG_C, 1'b0, 1'b1), "R3 low entry in large mode", d, tword(TG_C, 1'b0, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_data();
    t_outside();
    t_mismatch();
    t_clean();
    t_dirty();
    t_mode();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule